// File: doc/BRIEF.md
# Bank-Decoding Word ROM with Programmable Select Polarity

This block models a one-time-writable, word-wide memory of 16-bit words that does its own bank decoding. Three select inputs and an output enable are compared against four stored polarity bits. The data output is driven only when every select and the enable sit at their configured active levels. If eight copies are given the eight different select-polarity patterns and tied to one shared bus, any value on the three select lines wakes exactly one of them. No external decoder is needed.

The bus is modelled without tristate cells. Each copy presents a data vector together with a drive-enable flag. The drive-enable is combinational from the select and enable pins, so the enable acts without waiting for a clock. Read data comes from the word addressed `READ_LAT` clock edges earlier and stays put while the address is unchanged. Programming runs while the program-mode input is high. A normal write can only clear bits, so the stored word becomes the old word ANDed with the written word. A configuration write loads the polarity bits instead. An erase command returns every word to all ones and every polarity bit to one.

The full-size part uses `ADDR_W = 14`, which gives 16384 words. The default is smaller so that elaboration stays light. Reset clears the read register and the address pipeline, but it leaves the array and the polarity bits alone, because those are non-volatile.

Top module: `bank_rom`

## Requirements
- R1: When `progEn` is low, `dout` equals the stored word at the address presented `READ_LAT` rising edges earlier (default 1), and it keeps that value while the address and the array stay unchanged.
- R2: `doutEn` is high exactly when three conditions hold: `sel[i]` equals polarity bit i for every i in 0..2, `oe` equals polarity bit 3, and `progEn` is low. A polarity bit of 1 means active high and 0 means active low.
- R3: An `eraseCmd` edge sets every word to 16'hFFFF and all four polarity bits to 1.
- R4: With `progEn`, `progWr` high and `progCfg` low, the word at `addr` becomes its old value AND `progData`, all 16 bits in one edge.
- R5: With `progEn`, `progWr` and `progCfg` high, the polarity bits load from `progData[3:0]`. Bits 2..0 go to the selects and bit 3 goes to the enable. The array is left unchanged.
- R6: `progWr` while `progEn` is low changes neither the array nor the polarity bits.
- R7: While `progEn` is high, `doutEn` is low whatever the select and enable pins show.
- R8: When `eraseCmd` and a word write fall on the same edge, the erase wins and the word reads 16'hFFFF.
- R9: Take eight copies whose select polarity bits hold the patterns 0..7, with the enable active. For each of the eight select values, exactly one copy drives, and it is the copy whose pattern equals the select value.
- R10: `doutEn` follows a change on `oe` within the same clock cycle, with no clock edge in between.
- R11: While `rstN` is low, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset for the read path |
| addr | input | ADDR_W | Word address for reads and writes |
| sel | input | 3 | Chip-select pins, each compared to its polarity bit |
| oe | input | 1 | Output enable, compared to polarity bit 3 |
| progEn | input | 1 | Program mode; mutes the output |
| progWr | input | 1 | Write strobe in program mode |
| progCfg | input | 1 | Selects a polarity-bit write instead of a word write |
| progData | input | DATA_W | Write data, or polarity bits in [3:0] |
| eraseCmd | input | 1 | Restores the array and polarity bits to ones |
| dout | output | DATA_W | Read data |
| doutEn | output | 1 | Drive-enable for the shared bus |

## Verification
The bench targets the AND-only write. If a write overwrote the word instead of clearing bits, a second write to the same address would show the new pattern rather than the intersection of the two. It also drives an erase and a write onto the same edge. A design that put the write after the erase would leave the written pattern where all ones are expected. The bench sweeps every select and enable combination against a mixed polarity pattern, and it runs eight copies on one bus. A wrong sense on any polarity bit would show up as two drivers or none. Finally, it toggles `oe` between clock edges: an enable that had been registered by mistake would lag by one cycle.

// File: rtl/bank_rom_pkg.sv
package bank_rom_pkg;
  // Strobes from the control side to the storage side
  typedef struct packed {
    logic wr;     // clear-only word write
    logic erase;  // whole-array restore to ones
  } romStb_t;
endpackage

// File: rtl/bank_rom_ctrl.sv
module bank_rom_ctrl
  import bank_rom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_SEL  = 3,
  parameter int READ_LAT = 1,
  localparam int CFG_W   = NUM_SEL + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_SEL-1:0] sel,
  input  logic              oe,
  input  logic              progEn,
  input  logic              progWr,
  input  logic              progCfg,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              eraseCmd,
  output romStb_t           stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              doutEn
);
  logic [CFG_W-1:0]   polReg;
  logic [NUM_SEL-1:0] selHit;
  logic               cfgWr;

  assign cfgWr     = progEn & progWr & progCfg;
  assign stb.erase = eraseCmd;
  assign stb.wr    = progEn & progWr & ~progCfg & ~eraseCmd;

  // Polarity bits are non-volatile: only erase or a config write moves them
  always_ff @(posedge clk) begin
    if (eraseCmd)   polReg <= '1;
    else if (cfgWr) polReg <= cfgData;
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_selHit
    assign selHit[i] = ~(sel[i] ^ polReg[i]);
  end

  assign doutEn = (&selHit) & ~(oe ^ polReg[NUM_SEL]) & ~progEn;

  if (READ_LAT == 1) begin : g_direct
    assign rdAddr = addr;
  end else begin : g_pipe
    logic [ADDR_W-1:0] addrPipe [READ_LAT-1];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < READ_LAT - 1; i++) addrPipe[i] <= '0;
      end else begin
        addrPipe[0] <= addr;
        for (int i = 1; i < READ_LAT - 1; i++) addrPipe[i] <= addrPipe[i-1];
      end
    end
    assign rdAddr = addrPipe[READ_LAT-2];
  end

  p_prog_mute_r7: assert property (@(posedge clk) disable iff (!rstN)
    progEn |-> !doutEn);
  p_erase_pol_r3: assert property (@(posedge clk) disable iff (!rstN)
    eraseCmd |=> (polReg == '1));
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWr && !eraseCmd) |=> $stable(polReg));
  p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !eraseCmd) |=> (polReg == $past(cfgData)));
endmodule

// File: rtl/bank_rom_dp.sv
module bank_rom_dp
  import bank_rom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  romStb_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.wr) begin
      mem[wrAddr] <= mem[wrAddr] & wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end

  p_erase_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.erase |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
  p_bit_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |=> ((mem[$past(wrAddr)] & ~$past(mem[wrAddr])) == '0));
endmodule

// File: rtl/bank_rom.sv
module bank_rom
  import bank_rom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int READ_LAT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        sel,
  input  logic              oe,
  input  logic              progEn,
  input  logic              progWr,
  input  logic              progCfg,
  input  logic [DATA_W-1:0] progData,
  input  logic              eraseCmd,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn
);
  localparam int NUM_SEL = 3;
  localparam int CFG_W   = NUM_SEL + 1;

  romStb_t           stb;
  logic [ADDR_W-1:0] rdAddr;

  bank_rom_ctrl #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .READ_LAT(READ_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .oe(oe),
    .progEn(progEn), .progWr(progWr), .progCfg(progCfg),
    .cfgData(progData[CFG_W-1:0]), .eraseCmd(eraseCmd),
    .stb(stb), .rdAddr(rdAddr), .doutEn(doutEn)
  );

  bank_rom_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(addr), .wrData(progData),
    .rdAddr(rdAddr), .rdData(dout)
  );

  p_reset_zero_r11: assert property (@(posedge clk)
    !rstN |-> (dout == '0));
endmodule

// File: tb/bank_rom_tb.sv
module bank_rom_tb_top;
  localparam int CLK_P    = 10;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 16;
  localparam int READ_LAT = 1;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int NB       = 8;

  logic clk = 0;
  logic rstN = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0] sel = '0;
  logic oe = 0, progEn = 1, progCfg = 0, eraseCmd = 0;
  logic [NB-1:0] progWrV = '0;
  logic [DATA_W-1:0] progData = '0;
  logic [DATA_W-1:0] busDout [NB];
  logic [NB-1:0] busEn;

  int checks = 0, errors = 0;
  bit modelValid = 0, banksDistinct = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .oe(oe), .progEn(progEn),
    .progWr(progWrV[0]), .progCfg(progCfg), .progData(progData), .eraseCmd(eraseCmd),
    .dout(busDout[0]), .doutEn(busEn[0])
  );

  for (genvar k = 1; k < NB; k++) begin : bank_g
    bank_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)) bank_i (
      .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .oe(oe), .progEn(progEn),
      .progWr(progWrV[k]), .progCfg(progCfg), .progData(progData), .eraseCmd(eraseCmd),
      .dout(busDout[k]), .doutEn(busEn[k])
    );
  end

  // Behavioural reference for dut_i
  logic [DATA_W-1:0] refMem [DEPTH];
  logic [3:0]        refCfg = '0;
  logic [DATA_W-1:0] expDout = '0;
  logic [ADDR_W-1:0] addrQ [$];

  always @(posedge clk) begin
    logic [ADDR_W-1:0] rdA;
    if (!rstN) begin
      expDout = '0;
      addrQ.delete();
      for (int i = 0; i < READ_LAT - 1; i++) addrQ.push_back('0);
    end else begin
      if (READ_LAT == 1) rdA = addr;
      else begin rdA = addrQ.pop_front(); addrQ.push_back(addr); end
      expDout = refMem[rdA];
    end
    if (eraseCmd) begin
      for (int i = 0; i < DEPTH; i++) refMem[i] = '1;
      refCfg = 4'hF;
    end else if (progEn && progWrV[0]) begin
      if (progCfg) refCfg = progData[3:0];
      else refMem[addr] = refMem[addr] & progData;
    end
  end

  function automatic bit expEn();
    return (sel == refCfg[2:0]) && (oe == refCfg[3]) && !progEn;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelValid && rstN && !done) begin
      check(busDout[0] == expDout, "R1 cycle dout", 32'(busDout[0]), 32'(expDout));
      check(busEn[0] == expEn(), "R2 cycle doutEn", 32'(busEn[0]), 32'(expEn()));
      if (progEn) check(busEn == '0, "R7 cycle mute", 32'(busEn), 32'h0);
      if (banksDistinct) check($countones(busEn) <= 1, "R9 cycle single driver", 32'(busEn), 32'h1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic progWord(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [NB-1:0] m);
    progEn = 1; progCfg = 0; addr = a; progData = d; progWrV = m;
    cyc(1);
    progWrV = '0;
  endtask

  task automatic progPol(input logic [3:0] p, input logic [NB-1:0] m);
    progEn = 1; progCfg = 1; progData = {12'h0, p}; progWrV = m;
    cyc(1);
    progWrV = '0; progCfg = 0;
  endtask

  task automatic erase();
    eraseCmd = 1; cyc(1); eraseCmd = 0;
  endtask

  task automatic readChk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    addr = a;
    repeat (READ_LAT) @(negedge clk);
    check(busDout[0] == e, tag, 32'(busDout[0]), 32'(e));
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state
    cyc(3);
    check(busDout[0] == '0, "R11 reset dout", 32'(busDout[0]), 32'h0);
    check(busEn[0] == 1'b0, "R7 reset mute", 32'(busEn[0]), 32'h0);
    rstN = 1;
    erase();
    cyc(2);
    modelValid = 1;

    // Erased reads, default polarity all active high
    progEn = 0; sel = 3'b111; oe = 1;
    readChk(10'd5, 16'hFFFF, "R3 erased word");
    @(negedge clk);
    check(busEn[0] == 1'b1, "R2 default polarity drives", 32'(busEn[0]), 32'h1);
    #1;

    // Word writes clear bits only
    progWord(10'd5, 16'hA5C3, 8'h01);
    @(negedge clk);
    check(busEn[0] == 1'b0, "R7 program mode mutes", 32'(busEn[0]), 32'h0);
    #1;
    progWord(10'd5, 16'h0FF0, 8'h01);
    progWord(10'd9, 16'h1234, 8'h01);
    progEn = 0;
    readChk(10'd5, 16'h05C0, "R4 AND of two writes");
    readChk(10'd9, 16'h1234, "R4 whole word write");
    readChk(10'd0, 16'hFFFF, "R4 untouched word");
    addr = 10'd9;
    cyc(3);
    check(busDout[0] == 16'h1234, "R1 data held", 32'(busDout[0]), 32'h1234);

    // Write strobe ignored outside program mode
    progData = 16'h0000; progWrV = 8'h01; cyc(1); progWrV = '0;
    readChk(10'd9, 16'h1234, "R6 write outside program mode");

    // Polarity write leaves the array alone, then full sweep
    progPol(4'b0101, 8'h01);
    progEn = 0;
    readChk(10'd9, 16'h1234, "R5 array kept after config");
    for (int s = 0; s < 16; s++) begin
      sel = s[2:0]; oe = s[3];
      @(negedge clk);
      check(busEn[0] == (s == 5), "R2 polarity sweep", 32'(busEn[0]), 32'(s == 5));
      #1;
    end

    // Enable acts without a clock edge
    sel = 3'b101; oe = 1; cyc(1);
    oe = 0; #2;
    check(busEn[0] == 1'b1, "R10 oe assert same cycle", 32'(busEn[0]), 32'h1);
    oe = 1; #1;
    check(busEn[0] == 1'b0, "R10 oe release same cycle", 32'(busEn[0]), 32'h0);
    cyc(1);

    // Erase beats a simultaneous write
    progEn = 1; addr = 10'd9; progData = 16'h0000; progWrV = 8'h01; eraseCmd = 1;
    cyc(1);
    progWrV = '0; eraseCmd = 0;
    progEn = 0; sel = 3'b111; oe = 1;
    readChk(10'd9, 16'hFFFF, "R8 erase wins");
    readChk(10'd5, 16'hFFFF, "R3 erase clears array");

    // Eight banks on one bus
    for (int k = 0; k < NB; k++) progPol({1'b1, 3'(k)}, 8'(1 << k));
    for (int k = 0; k < NB; k++) progWord(10'd3, 16'(16'h1000 * k + k), 8'(1 << k));
    progEn = 0; oe = 1; addr = 10'd3;
    banksDistinct = 1;
    cyc(1);
    for (int s = 0; s < NB; s++) begin
      logic [DATA_W-1:0] bus;
      sel = 3'(s);
      @(negedge clk);
      bus = '0;
      for (int k = 0; k < NB; k++) if (busEn[k]) bus |= busDout[k];
      check(busEn == 8'(1 << s), "R9 one bank per pattern", 32'(busEn), 32'(1 << s));
      check(bus == 16'(16'h1000 * s + s), "R9 bus word", 32'(bus), 32'(16'h1000 * s + s));
      #1;
    end
    oe = 0;
    @(negedge clk);
    check(busEn == '0, "R2 enable inactive mutes all banks", 32'(busEn), 32'h0);
    #1;
    cyc(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule